// File: doc/BRIEF.md
# MAC Output Backend Datapath

This block conditions the raw result of a multiply-accumulate array before it goes to later stages. Each accepted sample passes through three steps. A programmable scaler shifts the MAC result arithmetically, left or right. A cascade adder then sums the scaled value with a signed word from an upstream device, or with zero. Last, an optional rectifier either clips negative sums to zero or takes their absolute value. Every arithmetic step saturates to the signed output range, so the output never wraps.

An eight-bit configuration register controls the block. It holds the signed shift amount, the cascade-zero select and a two-bit rectifier field. The datapath has one register stage. A valid flag travels alongside the data, and the output holds its last value while no sample is presented.

Top module: `mac_backend`

## Requirements
- R1: After reset, `outValid` is 0, `outData` is 0 and the configuration register is 0. That value means shift 0, cascade input used and straight-through rectifier, so a sample gives the saturated sum of `macIn` and `casIn`.
- R2: A sample presented with `inValid` high appears on `outData` with `outValid` high exactly one cycle later. A cycle without `inValid` gives `outValid` low in the next cycle, and `outData` keeps its previous value.
- R3: The configuration register is loaded from `cfgData` on a cycle with `cfgWe` high. Bits [7:3] are the two's-complement shift field, bit 2 is cascade-zero, bit 1 is full-wave and bit 0 is half-wave. A sample presented in the same cycle as a write still uses the old configuration. Samples in later cycles use the new one.
- R4: A shift field s in 1..8 shifts the MAC result right by s bits arithmetically, which rounds toward minus infinity. A shift field of 0 passes the MAC result unchanged, apart from saturation to the output width.
- R5: A shift field s in -8..-1 shifts the MAC result left by -s bits with zero fill. The result saturates to the most positive or most negative output value on overflow.
- R6: The cascade adder adds the scaled value and `casIn` as signed numbers, and the sum saturates to the output range.
- R7: With the cascade-zero bit set, zero replaces `casIn` in the adder. Any `casIn` value then has no effect on the output.
- R8: Rectifier field 00 passes the saturated sum unchanged.
- R9: Rectifier field 01 (half wave) replaces negative sums with zero and leaves non-negative sums unchanged.
- R10: Rectifier field 10 or 11 (full wave) outputs the absolute value of the sum, whatever the half-wave bit holds. The most negative value maps to the most positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration register write enable |
| cfgData | input | 8 | Configuration value to load |
| inValid | input | 1 | Sample on macIn/casIn is valid |
| macIn | input | MAC_W | Signed MAC array result |
| casIn | input | OUT_W | Signed cascade input from upstream |
| outValid | output | 1 | outData carries a new result |
| outData | output | OUT_W | Signed conditioned result |

## Verification
The bench builds the block with MAC_W = 8 and OUT_W = 8. At that size every MAC input value can be crossed with every legal shift from -8 to +8, which reaches left-shift overflow in both directions and right shifts down to -1 and 0. With the shift at zero, all 256 MAC values are crossed with sixteen cascade values spread over the full range and all eight cascade/rectifier settings. This reaches adder saturation at both ends, the most-negative input under full-wave rectification, and the full-over-half priority. Idle cycles and configuration writes are interleaved, so the hold behaviour and the write timing are checked during the same sweeps.

// File: rtl/macbe_pkg.sv
package macbe_pkg;
  // Configuration register geometry
  localparam int CFG_W     = 8;
  localparam int SHIFT_W   = 5;
  localparam int SHIFT_LSB = 3;
  localparam int ZERO_BIT  = 2;
  localparam int FULL_BIT  = 1;
  localparam int HALF_BIT  = 0;
  // Largest legal left shift; sets the scaler's guard width
  localparam int MAX_SHIFT = 8;

  // Decoded strobes handed from control to datapath
  typedef struct packed {
    logic               load;
    logic               shiftLeft;
    logic [SHIFT_W-1:0] shiftAmt;
    logic               zeroCas;
    logic               rectAbs;
    logic               rectClip;
  } beStrobe_t;
endpackage

// File: rtl/macbe_ctrl.sv
module macbe_ctrl
  import macbe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             inValid,
  output beStrobe_t        strb
);
  logic [CFG_W-1:0]   cfgReg;
  logic [SHIFT_W-1:0] shiftField;
  logic [SHIFT_W-1:0] shiftMag;
  logic               shiftNeg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgData;
  end

  assign shiftField = cfgReg[SHIFT_LSB +: SHIFT_W];
  assign shiftNeg   = shiftField[SHIFT_W-1];
  assign shiftMag   = shiftNeg ? (~shiftField + 1'b1) : shiftField;

  always_comb begin
    strb.load      = inValid;
    strb.shiftLeft = shiftNeg;
    strb.shiftAmt  = shiftMag;
    strb.zeroCas   = cfgReg[ZERO_BIT];
    // full-wave wins over half-wave
    strb.rectAbs   = cfgReg[FULL_BIT];
    strb.rectClip  = cfgReg[HALF_BIT] & ~cfgReg[FULL_BIT];
  end

  // R3
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgReg == $past(cfgData));
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(cfgReg));
endmodule

// File: rtl/macbe_scaler.sv
module macbe_scaler
  import macbe_pkg::*;
#(
  parameter int MAC_W = 24,
  parameter int OUT_W = 24
) (
  input  logic [MAC_W-1:0]   din,
  input  logic               shiftLeft,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output logic [OUT_W-1:0]   dout
);
  localparam int EXT_W = MAC_W + MAX_SHIFT;
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [EXT_W-1:0] extVal;
  logic signed [EXT_W-1:0] shifted;

  assign extVal  = {{MAX_SHIFT{din[MAC_W-1]}}, din};
  assign shifted = shiftLeft ? (extVal <<< shiftAmt) : (extVal >>> shiftAmt);

  generate
    if (EXT_W > OUT_W) begin : g_sat
      logic [EXT_W-OUT_W:0] topBits;
      logic                 fits;
      assign topBits = shifted[EXT_W-1:OUT_W-1];
      assign fits    = (&topBits) | ~(|topBits);
      assign dout    = fits ? shifted[OUT_W-1:0]
                            : (shifted[EXT_W-1] ? OUT_MIN : OUT_MAX);
    end else if (EXT_W == OUT_W) begin : g_same
      assign dout = shifted;
    end else begin : g_ext
      assign dout = {{(OUT_W-EXT_W){shifted[EXT_W-1]}}, shifted};
    end
  endgenerate

  // R4: a right shift never changes the sign
  right_sign_chk: assert final (shiftLeft || shiftAmt > SHIFT_W'(MAX_SHIFT)
                                || dout[OUT_W-1] == din[MAC_W-1]);
endmodule

// File: rtl/macbe_datapath.sv
module macbe_datapath
  import macbe_pkg::*;
#(
  parameter int MAC_W = 24,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  beStrobe_t        strb,
  input  logic [MAC_W-1:0] macIn,
  input  logic [OUT_W-1:0] casIn,
  output logic             outValid,
  output logic [OUT_W-1:0] outData
);
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W-1:0] scaled;
  logic [OUT_W-1:0] casSel;
  logic [OUT_W:0]   sumWide;
  logic [OUT_W-1:0] sumSat;
  logic [OUT_W-1:0] absVal;
  logic [OUT_W-1:0] rectVal;
  logic             sumOvf;
  logic             sumNeg;

  macbe_scaler #(.MAC_W(MAC_W), .OUT_W(OUT_W)) scaler_i (
    .din      (macIn),
    .shiftLeft(strb.shiftLeft),
    .shiftAmt (strb.shiftAmt),
    .dout     (scaled)
  );

  // cascade adder with saturation
  assign casSel  = strb.zeroCas ? '0 : casIn;
  assign sumWide = {scaled[OUT_W-1], scaled} + {casSel[OUT_W-1], casSel};
  assign sumOvf  = sumWide[OUT_W] ^ sumWide[OUT_W-1];
  assign sumSat  = sumOvf ? (sumWide[OUT_W] ? OUT_MIN : OUT_MAX)
                          : sumWide[OUT_W-1:0];

  // rectifier
  assign sumNeg = sumSat[OUT_W-1];
  assign absVal = (sumSat == OUT_MIN) ? OUT_MAX : (~sumSat + 1'b1);

  always_comb begin
    rectVal = sumSat;
    if (strb.rectAbs) begin
      if (sumNeg) rectVal = absVal;
    end else if (strb.rectClip) begin
      if (sumNeg) rectVal = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strb.load;
      if (strb.load) outData <= rectVal;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> outValid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !outValid && $stable(outData));
  // R9
  half_nonneg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.rectClip) |=> !outData[OUT_W-1]);
  // R10
  full_nonneg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.rectAbs) |=> !outData[OUT_W-1]);
  // R7
  zero_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.zeroCas && !strb.rectAbs && !strb.rectClip)
      |=> outData == $past(scaled));
endmodule

// File: rtl/mac_backend.sv
module mac_backend
  import macbe_pkg::*;
#(
  parameter int MAC_W = 24,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [7:0]       cfgData,
  input  logic             inValid,
  input  logic [MAC_W-1:0] macIn,
  input  logic [OUT_W-1:0] casIn,
  output logic             outValid,
  output logic [OUT_W-1:0] outData
);
  beStrobe_t strb;

  macbe_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .cfgWe  (cfgWe),
    .cfgData(cfgData),
    .inValid(inValid),
    .strb   (strb)
  );

  macbe_datapath #(.MAC_W(MAC_W), .OUT_W(OUT_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .macIn   (macIn),
    .casIn   (casIn),
    .outValid(outValid),
    .outData (outData)
  );
endmodule

// File: tb/mac_backend_tb_top.sv
module mac_backend_tb_top;
  localparam int MW = 8;
  localparam int OW = 8;
  localparam int OMAX = (1 << (OW-1)) - 1;
  localparam int OMIN = -(1 << (OW-1));

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [7:0]    cfgData = '0;
  logic          inValid = 1'b0;
  logic [MW-1:0] macIn = '0;
  logic [OW-1:0] casIn = '0;
  logic          outValid;
  logic [OW-1:0] outData;

  int     nChecks = 0;
  int     nFails  = 0;
  bit     done    = 1'b0;
  bit     pendValid = 1'b0;
  int     pendExp = 0;
  int     lastOut = 0;
  string  pendTag = "R1";
  logic [7:0] modelCfg = '0;

  always #5 clk = ~clk;

  mac_backend #(.MAC_W(MW), .OUT_W(OW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .inValid(inValid), .macIn(macIn), .casIn(casIn),
    .outValid(outValid), .outData(outData)
  );

  function automatic int sat(int v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  // Arithmetic reference built from R4..R10
  function automatic int model(int mac, int cas, logic [7:0] cfg);
    int s = $signed(cfg[7:3]);
    int v;
    int c;
    if (s >= 0) v = mac >>> s;
    else        v = mac * (1 << (-s));
    v = sat(v);
    c = cfg[2] ? 0 : cas;
    v = sat(v + c);
    if (cfg[1])      v = sat((v < 0) ? -v : v);
    else if (cfg[0]) v = (v < 0) ? 0 : v;
    return v;
  endfunction

  task automatic checkPending();
    int act = $signed(outData);
    bit ok;
    nChecks++;
    if (pendValid) begin
      ok = (outValid === 1'b1) && (act == pendExp);
      if (!ok) $display("FAIL %s: outValid=%0b outData=%0d expected valid=1 data=%0d",
                        pendTag, outValid, act, pendExp);
      lastOut = pendExp;
    end else begin
      ok = (outValid === 1'b0) && (act == lastOut);
      if (!ok) $display("FAIL %s: outValid=%0b outData=%0d expected valid=0 data=%0d",
                        pendTag, outValid, act, lastOut);
    end
    if (!ok) nFails++;
  endtask

  task automatic drive(bit v, int mac, int cas, bit we, logic [7:0] cfg, string tag);
    @(negedge clk);
    checkPending();
    inValid = v;
    macIn   = mac[MW-1:0];
    casIn   = cas[OW-1:0];
    cfgWe   = we;
    cfgData = cfg;
    pendValid = v;
    pendTag   = tag;
    if (v) pendExp = model(mac, cas, modelCfg);
    if (we) modelCfg = cfg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, then default configuration
    drive(1'b0, 0, 0, 1'b0, 8'h00, "R1");
    drive(1'b1, 5, 3, 1'b0, 8'h00, "R1");
    drive(1'b1, -7, 100, 1'b0, 8'h00, "R1");
    drive(1'b1, 100, 100, 1'b0, 8'h00, "R1");
    // R3: write and sample in the same cycle use the old setting
    drive(1'b1, 40, 1, 1'b1, {5'd2, 3'b000}, "R3");
    drive(1'b1, 40, 1, 1'b0, 8'h00, "R3");
    drive(1'b0, 0, 0, 1'b1, {5'd0, 3'b111}, "R2");
    drive(1'b1, -50, 20, 1'b0, 8'h00, "R3");
    // Shift sweep: R4 right, R5 left, R8 straight at zero shift
    for (int s = -8; s <= 8; s++) begin
      logic [4:0] sf = s[4:0];
      drive(1'b0, 0, 0, 1'b1, {sf, 3'b000}, "R2");
      for (int m = -128; m < 128; m++) begin
        if ((m & 31) == 7) drive(1'b0, 0, 0, 1'b0, 8'h00, "R2");
        if (s > 0)      drive(1'b1, m, 0, 1'b0, 8'h00, "R4");
        else if (s < 0) drive(1'b1, m, 0, 1'b0, 8'h00, "R5");
        else            drive(1'b1, m, 0, 1'b0, 8'h00, "R8");
      end
    end
    // Adder and rectifier sweep: R6 sum, R7 zero cascade, R9 half, R10 full
    for (int md = 0; md < 8; md++) begin
      logic [2:0] mb = md[2:0];
      drive(1'b0, 0, 0, 1'b1, {5'd0, mb}, "R2");
      for (int m = -128; m < 128; m++) begin
        for (int c = -128; c < 128; c += 17) begin
          if (mb[1])      drive(1'b1, m, c, 1'b0, 8'h00, "R10");
          else if (mb[0]) drive(1'b1, m, c, 1'b0, 8'h00, "R9");
          else if (mb[2]) drive(1'b1, m, c, 1'b0, 8'h00, "R7");
          else            drive(1'b1, m, c, 1'b0, 8'h00, "R6");
        end
        if ((m & 63) == 3) drive(1'b0, 0, 0, 1'b0, 8'h00, "R2");
      end
    end
    drive(1'b0, 0, 0, 1'b0, 8'h00, "R2");
    drive(1'b0, 0, 0, 1'b0, 8'h00, "R2");
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule